// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Core

A single-port synchronous memory with a 64-bit word split into eight byte lanes and a parameterised depth. Every address, enable, strobe, write-control and write-data input is sampled on the rising clock edge. Read data leaves through an output register, so a read started by an address strobe is readable on the third clock counting the strobe's own edge. A burst then delivers one word per clock while the advance input is held low.

An access is started by one of two address strobes. The processor-side strobe always reads and is gated by the primary chip enable. The controller-side strobe may read or write. Later burst addresses come from an internal two-bit counter, which steps either linearly or in an interleaved (XOR) order within an aligned group of four words. Writes are masked per byte lane, or the global-write input forces all lanes. Five chip enables, three active low and two active high, allow several banks to share one bus. The output enable gates the data output asynchronously, and `dValid` marks the cycles in which the output carries read data.

Top module: `sbsram_core`

## Requirements
- R1: With `gwN`=1 and `bweN`=0, a write changes exactly the lanes n whose `bwN[n]`=0. Lane n is data bits 8n+7 down to 8n, and all other lanes keep their old contents.
- R2: With `gwN`=0, a write changes all eight lanes, whatever `bweN` and `bwN` are.
- R3: When `gwN`=1 and either `bweN`=1 or `bwN` is all ones, no lane is written, and a controller-strobe cycle becomes a read.
- R4: While `oeN`=1, `dOut` is all zeros and `dValid`=0 in the same cycle, with no clock edge needed. When `oeN` returns low, the registered word reappears without a clock edge.
- R5: A low `adspN` is ignored while `ceN`=1. That cycle is then decided by `adscN` and `advN` alone. A low `adspN` with `ceN`=0 takes priority over `adscN`.
- R6: An access starts only when `ceN`, `ce2N` and `ce3N` are 0 and `ce2` and `ce3` are 1. A strobe that is taken while any enable is inactive deselects the device. `dValid` is then 0 after the next edge, and burst-advance cycles are ignored until the next access starts.
- R7: A read strobe sampled at edge k puts the word on `dOut`, with `dValid`=1, after edge k+1. A read advance at edge k+1 puts the next word out after edge k+2.
- R8: For a burst with base address B and step count n (which wraps modulo 4), the upper address bits stay those of B. The two low bits are (B+n) mod 4 when `modeLinear`=1 and B XOR n when `modeLinear`=0.
- R9: A cycle started by `adspN` with `ceN`=0 is always a read, even when the write controls are asserted.
- R10: A write on a controller-strobe or advance cycle is committed at that edge. A read strobe on the very next edge returns the new data.
- R11: With `adspN`, `adscN` and `advN` all high, the burst address is held and no access is made. `dValid` is 0 after the next edge, and a later advance continues from the held address.
- R12: While `rstN`=0 and after reset, `dValid`=0 until the first read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of the control state |
| addrIn | input | ADDR_W | Word address loaded by a strobe |
| ceN | input | 1 | Primary chip enable, active low; gates `adspN` |
| ce2N | input | 1 | Depth-expansion enable, active low |
| ce3N | input | 1 | Depth-expansion enable, active low |
| ce2 | input | 1 | Depth-expansion enable, active high |
| ce3 | input | 1 | Depth-expansion enable, active high |
| adspN | input | 1 | Processor address strobe, active low, read only |
| adscN | input | 1 | Controller address strobe, active low |
| advN | input | 1 | Burst advance, active low |
| gwN | input | 1 | Global write, active low, all lanes |
| bweN | input | 1 | Byte-write enable, active low |
| bwN | input | 8 | Per-lane byte writes, active low |
| modeLinear | input | 1 | Burst order: 1 linear, 0 interleaved |
| dIn | input | 64 | Write data |
| oeN | input | 1 | Asynchronous output enable, active low |
| dOut | output | 64 | Registered read data, zero when not valid |
| dValid | output | 1 | Output carries read data |

## Verification
The hardest case to reach is a burst that wraps inside its aligned group of four in the interleaved order while write controls are also present. Reaching it requires a strobe that is taken followed by four or more advances. The stimulus runs both burst orders from a base address that is not aligned, then does a burst write through advance cycles and reads it back. It also checks that the two strobes interact correctly: a processor strobe that is gated off falls through to a controller strobe that deselects, and the advances that follow must do nothing. A behavioural model in the bench tracks the burst base, step count and selection and checks the output on every clock.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  localparam int LANES  = 8;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;
  localparam int CNT_W  = 2;

  typedef struct packed {
    logic             load;      // take addrIn as new burst base
    logic             advance;   // step the burst counter
    logic             deselect;  // drop selection
    logic             rdEn;      // schedule an output register load
    logic [LANES-1:0] wrMask;    // lanes to commit this edge
  } ctl_strb_t;
endpackage

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
  import sbsram_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceN,
  input  logic             ce2N,
  input  logic             ce3N,
  input  logic             ce2,
  input  logic             ce3,
  input  logic             adspN,
  input  logic             adscN,
  input  logic             advN,
  input  logic             gwN,
  input  logic             bweN,
  input  logic [LANES-1:0] bwN,
  output ctl_strb_t        strb
);
  logic             selQ;
  logic             enAll;
  logic [LANES-1:0] laneReq;

  // R6: all five enables must be active
  assign enAll = ~ceN & ~ce2N & ~ce3N & ce2 & ce3;

  // R1 R2 R3: global write overrides, byte writes need bweN low
  always_comb begin
    if (!gwN)       laneReq = '1;
    else if (!bweN) laneReq = ~bwN;
    else            laneReq = '0;
  end

  always_comb begin
    strb = '0;
    if (!adspN && !ceN) begin
      // R9: processor strobe is read only; R5: wins over adscN
      if (enAll) begin
        strb.load = 1'b1;
        strb.rdEn = 1'b1;
      end else begin
        strb.deselect = 1'b1;
      end
    end else if (!adscN) begin
      if (enAll) begin
        strb.load   = 1'b1;
        strb.wrMask = laneReq;
        strb.rdEn   = (laneReq == '0);
      end else begin
        strb.deselect = 1'b1;
      end
    end else if (!advN && selQ) begin
      strb.advance = 1'b1;
      strb.wrMask  = laneReq;
      strb.rdEn    = (laneReq == '0);
    end
    // R11: otherwise nothing happens
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              selQ <= 1'b0;
    else if (strb.load)     selQ <= 1'b1;
    else if (strb.deselect) selQ <= 1'b0;
  end
endmodule

// File: rtl/sbsram_burst.sv
module sbsram_burst
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic              advance,
  input  logic              modeLinear,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] curAddr,
  output logic [ADDR_W-1:0] nextAddr
);
  logic [ADDR_W-1:0] baseQ, curQ, stepAddr;
  logic [CNT_W-1:0]  cntQ, cntNext, lowBits;

  assign cntNext = cntQ + 1'b1;

  // R8: linear adds the count, interleaved XORs it, upper bits fixed
  always_comb begin
    if (modeLinear) lowBits = baseQ[CNT_W-1:0] + cntNext;
    else            lowBits = baseQ[CNT_W-1:0] ^ cntNext;
    stepAddr = {baseQ[ADDR_W-1:CNT_W], lowBits};
  end

  always_comb begin
    if (load)         nextAddr = addrIn;
    else if (advance) nextAddr = stepAddr;
    else              nextAddr = curQ;   // R11: hold
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= '0;
      cntQ  <= '0;
      curQ  <= '0;
    end else begin
      if (load) begin
        baseQ <= addrIn;
        cntQ  <= '0;
      end else if (advance) begin
        cntQ  <= cntNext;
      end
      curQ <= nextAddr;
    end
  end

  assign curAddr = curQ;
endmodule

// File: rtl/sbsram_datapath.sv
module sbsram_datapath
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strb_t         strb,
  input  logic [ADDR_W-1:0] curAddr,
  input  logic [ADDR_W-1:0] nextAddr,
  input  logic [WORD_W-1:0] dIn,
  input  logic              oeN,
  output logic [WORD_W-1:0] dOut,
  output logic              dValid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANES-1:0][LANE_W-1:0] rdLanes;
  logic [WORD_W-1:0]            outQ;
  logic                         pendQ, validQ;

  // one storage array per byte lane (R1 R2)
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];
    always_ff @(posedge clk) begin
      if (strb.wrMask[g]) laneMem[nextAddr] <= dIn[g*LANE_W +: LANE_W]; // R10
    end
    assign rdLanes[g] = laneMem[curAddr];
  end

  // R7: address register then output register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ  <= 1'b0;
      validQ <= 1'b0;
      outQ   <= '0;
    end else begin
      pendQ  <= strb.rdEn;
      validQ <= pendQ;
      if (pendQ) outQ <= rdLanes;
    end
  end

  // R4: asynchronous output gating
  assign dValid = validQ & ~oeN;
  assign dOut   = dValid ? outQ : '0;
endmodule

// File: rtl/sbsram_core.sv
module sbsram_core
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              ceN,
  input  logic              ce2N,
  input  logic              ce3N,
  input  logic              ce2,
  input  logic              ce3,
  input  logic              adspN,
  input  logic              adscN,
  input  logic              advN,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [7:0]        bwN,
  input  logic              modeLinear,
  input  logic [63:0]       dIn,
  input  logic              oeN,
  output logic [63:0]       dOut,
  output logic              dValid
);
  ctl_strb_t         ctlStrb;
  logic [ADDR_W-1:0] curAddr, nextAddr;

  sbsram_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .ce2N(ce2N), .ce3N(ce3N),
    .ce2(ce2), .ce3(ce3), .adspN(adspN), .adscN(adscN), .advN(advN),
    .gwN(gwN), .bweN(bweN), .bwN(bwN), .strb(ctlStrb)
  );

  sbsram_burst #(.ADDR_W(ADDR_W)) burst_i (
    .clk(clk), .rstN(rstN), .load(ctlStrb.load), .advance(ctlStrb.advance),
    .modeLinear(modeLinear), .addrIn(addrIn), .curAddr(curAddr),
    .nextAddr(nextAddr)
  );

  sbsram_datapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(ctlStrb), .curAddr(curAddr),
    .nextAddr(nextAddr), .dIn(dIn), .oeN(oeN), .dOut(dOut), .dValid(dValid)
  );
endmodule

// File: rtl/sbsram_core_chk.sv
module sbsram_core_chk
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              ce2N,
  input logic              ce3N,
  input logic              ce2,
  input logic              ce3,
  input logic              adspN,
  input logic              adscN,
  input logic              advN,
  input logic              gwN,
  input logic              oeN,
  input logic              dValid,
  input ctl_strb_t         strb,
  input logic [ADDR_W-1:0] curAddr
);
  logic enAll;
  assign enAll = !ceN && !ce2N && !ce3N && ce2 && ce3;

  p_adsp_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!adspN && !ceN) |-> (strb.wrMask == '0));

  p_gw_all_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!gwN && strb.wrMask != '0) |-> (strb.wrMask == '1));

  p_latency_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdEn |=> ##1 (dValid || oeN));

  p_deselect_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!enAll && (!adscN || (!adspN && !ceN))) |=> ##1 !dValid);

  p_ce_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!adspN && ceN && adscN && advN) |-> (!strb.load && !strb.deselect));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (adspN && adscN && advN) |=> ($stable(curAddr) && !$past(strb.rdEn)));

  p_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    (adspN && adscN && advN) |=> ##1 !dValid);
endmodule

bind sbsram_core sbsram_core_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .ceN(ceN), .ce2N(ce2N), .ce3N(ce3N),
  .ce2(ce2), .ce3(ce3), .adspN(adspN), .adscN(adscN), .advN(advN),
  .gwN(gwN), .oeN(oeN), .dValid(dValid), .strb(ctlStrb), .curAddr(curAddr)
);

// File: tb/sbsram_core_tb_top.sv
module sbsram_core_tb_top;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN;
  logic [AW-1:0] addrIn;
  logic          ceN, ce2N, ce3N, ce2, ce3;
  logic          adspN, adscN, advN, gwN, bweN;
  logic [7:0]    bwN;
  logic          modeLinear;
  logic [63:0]   dIn;
  logic          oeN;
  logic [63:0]   dOut;
  logic          dValid;

  always #5 clk = ~clk;

  sbsram_core #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .ceN(ceN), .ce2N(ce2N),
    .ce3N(ce3N), .ce2(ce2), .ce3(ce3), .adspN(adspN), .adscN(adscN),
    .advN(advN), .gwN(gwN), .bweN(bweN), .bwN(bwN),
    .modeLinear(modeLinear), .dIn(dIn), .oeN(oeN), .dOut(dOut),
    .dValid(dValid)
  );

  // behavioural reference state
  logic [63:0] mm [DEPTH];
  int          mBase, mCnt, mCur;
  bit          mSel, mPend, mValid;
  logic [63:0] mData;

  int    nChecks = 0, nFails = 0;
  bit    finished = 0;
  string curTag = "R12";

  function automatic logic [63:0] pat(input int i);
    return {8'(i), 8'hA5, 16'(i * 7), 32'h1357_0000 + 32'(i)};
  endfunction

  function automatic int burstAddr(input int b, input int n, input bit lin);
    int lo;
    lo = lin ? ((b + n) & 3) : ((b ^ n) & 3);
    return (b & ~3) | lo;
  endfunction

  task automatic modelEdge();
    bit       en;
    bit [7:0] m;
    if (mPend) begin mData = mm[mCur]; mValid = 1; end
    else mValid = 0;
    en = !ceN && !ce2N && !ce3N && ce2 && ce3;
    m = !gwN ? 8'hFF : (!bweN ? ~bwN : 8'h00);
    if (!adspN && !ceN) begin
      if (en) begin mSel = 1; mBase = int'(addrIn); mCnt = 0; mCur = mBase; mPend = 1; end
      else begin mSel = 0; mPend = 0; end
    end else if (!adscN) begin
      if (en) begin
        mSel = 1; mBase = int'(addrIn); mCnt = 0; mCur = mBase;
        mPend = (m == 0);
        for (int l = 0; l < 8; l++) if (m[l]) mm[mCur][l*8 +: 8] = dIn[l*8 +: 8];
      end else begin mSel = 0; mPend = 0; end
    end else if (!advN && mSel) begin
      mCnt = (mCnt + 1) & 3;
      mCur = burstAddr(mBase, mCnt, modeLinear);
      mPend = (m == 0);
      for (int l = 0; l < 8; l++) if (m[l]) mm[mCur][l*8 +: 8] = dIn[l*8 +: 8];
    end else begin
      mPend = 0;
    end
  endtask

  task automatic compare();
    bit expV;
    logic [63:0] expD;
    expV = mValid && !oeN;
    expD = expV ? mData : 64'h0;
    nChecks++;
    if (dValid !== expV || dOut !== expD) begin
      nFails++;
      $display("FAIL %s: dValid=%0b dOut=%h expected dValid=%0b dOut=%h",
               curTag, dValid, dOut, expV, expD);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1 modelEdge();
    @(negedge clk);
    compare();
  endtask

  task automatic setIdle();
    adspN = 1; adscN = 1; advN = 1; gwN = 1; bweN = 1; bwN = 8'hFF;
    ceN = 0; ce2N = 0; ce3N = 0; ce2 = 1; ce3 = 1; dIn = '0;
  endtask

  task automatic idleCyc(input int n);
    for (int i = 0; i < n; i++) begin setIdle(); tick(); end
  endtask

  task automatic adspRead(input int a);
    setIdle(); adspN = 0; addrIn = AW'(a); tick();
  endtask

  task automatic adscOp(input int a, input bit g, input bit be,
                        input logic [7:0] bw, input logic [63:0] d);
    setIdle(); adscN = 0; addrIn = AW'(a); gwN = g; bweN = be; bwN = bw; dIn = d;
    tick();
  endtask

  task automatic advOp(input bit g, input bit be, input logic [7:0] bw,
                       input logic [63:0] d);
    setIdle(); advN = 0; gwN = g; bweN = be; bwN = bw; dIn = d; tick();
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    nFails++;
    $display("FAIL watchdog: run still active, expected completion");
    finish();
  end

  initial begin
    rstN = 0; setIdle(); addrIn = '0; modeLinear = 1; oeN = 0;
    mSel = 0; mPend = 0; mValid = 0; mCur = 0; mBase = 0; mCnt = 0; mData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    curTag = "R12";
    compare();
    rstN = 1;
    idleCyc(2);

    // preload every word with global writes
    curTag = "R2";
    for (int i = 0; i < DEPTH; i++) adscOp(i, 0, 1, 8'hFF, pat(i));
    idleCyc(1);

    curTag = "R7";
    adspRead(5); idleCyc(3);

    curTag = "R8";
    modeLinear = 1;
    adspRead(6); advOp(1, 1, 8'hFF, '0); advOp(1, 1, 8'hFF, '0);
    advOp(1, 1, 8'hFF, '0); advOp(1, 1, 8'hFF, '0); idleCyc(2);
    modeLinear = 0;
    adspRead(37); advOp(1, 1, 8'hFF, '0); advOp(1, 1, 8'hFF, '0);
    advOp(1, 1, 8'hFF, '0); advOp(1, 1, 8'hFF, '0); idleCyc(2);
    modeLinear = 1;

    curTag = "R1";
    adscOp(9, 1, 0, 8'hAA, 64'hFFEE_DDCC_BBAA_9988);
    adspRead(9); idleCyc(2);

    curTag = "R2";
    adscOp(10, 0, 1, 8'hFF, 64'h0123_4567_89AB_CDEF);
    adspRead(10); idleCyc(2);

    curTag = "R3";
    adscOp(11, 1, 1, 8'h00, 64'hDEAD_BEEF_DEAD_BEEF); idleCyc(2);
    adscOp(11, 1, 0, 8'hFF, 64'hDEAD_BEEF_DEAD_BEEF); idleCyc(2);

    curTag = "R9";
    setIdle(); adspN = 0; addrIn = AW'(12); gwN = 0; dIn = 64'hBAD0_BAD0_BAD0_BAD0; tick();
    idleCyc(1); adspRead(12); idleCyc(2);

    curTag = "R5";
    adspRead(13);
    setIdle(); adspN = 0; ceN = 1; addrIn = AW'(50); tick();
    advOp(1, 1, 8'hFF, '0); idleCyc(2);
    setIdle(); adspN = 0; ceN = 1; adscN = 0; addrIn = AW'(20); tick();
    advOp(1, 1, 8'hFF, '0); idleCyc(2);

    curTag = "R6";
    adspRead(21);
    setIdle(); adscN = 0; ce2 = 0; addrIn = AW'(22); tick();
    advOp(1, 1, 8'hFF, '0); advOp(1, 1, 8'hFF, '0); idleCyc(1);
    adspRead(23);
    setIdle(); adspN = 0; ce3N = 1; addrIn = AW'(24); tick();
    advOp(1, 1, 8'hFF, '0); idleCyc(2);
    adspRead(25);
    setIdle(); adscN = 0; ce2N = 1; ce3 = 0; addrIn = AW'(26); tick();
    idleCyc(2);

    curTag = "R11";
    adspRead(30); idleCyc(3); advOp(1, 1, 8'hFF, '0); idleCyc(3);

    curTag = "R4";
    adspRead(40);
    setIdle();
    @(posedge clk); #1 modelEdge();
    @(negedge clk); compare();
    #2 oeN = 1;
    #1 nChecks++;
    if (dOut !== 64'h0 || dValid !== 1'b0) begin
      nFails++;
      $display("FAIL R4: oe high dOut=%h dValid=%0b expected 0 and 0", dOut, dValid);
    end
    oeN = 0;
    #1 nChecks++;
    if (dOut !== pat(40) || dValid !== 1'b1) begin
      nFails++;
      $display("FAIL R4: oe low dOut=%h dValid=%0b expected %h and 1", dOut, dValid, pat(40));
    end
    adspRead(41); oeN = 1; idleCyc(1); oeN = 0; idleCyc(2);

    curTag = "R10";
    adscOp(48, 0, 1, 8'hFF, 64'h1111_0000_0000_1111);
    advOp(0, 1, 8'hFF, 64'h2222_0000_0000_2222);
    advOp(1, 0, 8'h0F, 64'h3333_3333_3333_3333);
    advOp(0, 1, 8'hFF, 64'h4444_0000_0000_4444);
    adspRead(48); advOp(1, 1, 8'hFF, '0); advOp(1, 1, 8'hFF, '0);
    advOp(1, 1, 8'hFF, '0); idleCyc(2);
    adscOp(55, 0, 1, 8'hFF, 64'h5555_AAAA_5555_AAAA);
    adspRead(55); idleCyc(2);

    finish();
  end
endmodule